// File: doc/BRIEF.md
# LIN Frame Error Monitor

This block sits beside a LIN bus controller and gathers the faults seen while frames move on the bus. The frame engine hands it event strobes: a measured bit period from the sync field, the received protected identifier, the outcome of the checksum comparison, and the driven and sampled bit during transmission. It also hands it frame milestones (start, header complete, byte complete, frame complete), the data length, bit-time ticks and the application's acknowledge and stop strobes. Each fault sets one bit of an 8-bit status value that software reads.

The bits are sticky. A one-cycle clear command empties the whole status value, but an error event in that same cycle still sets its bit. Sync and parity faults count only when the node runs as a slave. The timeout bit merges three watchdogs:

- a frame-length limit of 1.4 times the nominal frame time;
- a response-window limit after the header;
- a handshake deadline that requires an acknowledge or stop before the first byte after the identifier completes.

The frame tracker has four named states:

| State | Meaning |
|---|---|
| ST_IDLE | No frame is in progress. |
| ST_HEADER | The break, sync and identifier are under way. |
| ST_AWAIT | The header is done and the first data byte is pending. |
| ST_DATA | Data bytes are flowing. |

Its transitions are:

- **start**: any state goes to ST_HEADER on `frame_start`, which also restarts the timers.
- **hdr_done**: ST_HEADER goes to ST_AWAIT on `header_done`.
- **first_byte**: ST_AWAIT goes to ST_DATA on `byte_rx`.
- **finish**: any active state goes to ST_IDLE on `frame_done`.
- **abort**: any active state goes to ST_IDLE when a timeout fires.

Top module: `lin_err_monitor`

## Requirements
- R1: After reset `err_status` is 0x00. Bits 7..5 always read 0.
- R2: Bit 4 (sync fault) is set when `sync_valid` is high in slave mode and `sync_meas` lies outside NOM_BIT ± floor(NOM_BIT·TOL_PCT/100). With the defaults (160, 14) the accepted range is 138..182 inclusive. In master mode the event is ignored.
- R3: Bit 3 (parity fault) is set when `pid_valid` is high in slave mode and either parity bit fails to match. The identifier is `pid[5:0]`. The check requires `pid[6]` = id0^id1^id2^id4 and `pid[7]` = ~(id1^id3^id4^id5). In master mode the event is ignored.
- R4: Bit 1 (checksum fault) is set when `chk_valid` is high and `chk_ok` is low.
- R5: Bit 0 (transmit bit fault) is set when `bit_sample` and `tx_active` are high and `tx_bit` differs from `rx_bit`.
- R6: Bit 2 (timeout) is set on the bit tick that brings the ticks since `frame_start` to floor((34+10·(N+1))·14/10), while a frame is active. N is `data_len`, latched at `frame_start`. For N=1 this is 75 ticks, and for N=8 it is 173 ticks.
- R7: Bit 2 is set on the RESP_TICKS-th (default 14) bit tick in ST_AWAIT if no byte has completed by then.
- R8: Bit 2 is set when the first byte after the header completes (`byte_rx` in ST_AWAIT) without an `app_ack` or `app_stop` since `frame_start`. A strobe in the same cycle counts as given.
- R9: Status bits stay set until `err_clr`. On `err_clr` all bits clear in one cycle, except bits whose event occurs in that same cycle.
- R10: The timers run only while a frame is active. After `frame_done`, ticks cause no timeout. A new `frame_start` restarts the frame-length count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| bit_tick | input | 1 | One pulse per bit time |
| frame_start | input | 1 | Frame (break) begins |
| header_done | input | 1 | Protected identifier received |
| byte_rx | input | 1 | A data or checksum byte completed |
| frame_done | input | 1 | Frame completed |
| data_len | input | LEN_W (4) | Data bytes in this frame, 1..MAX_BYTES |
| app_ack | input | 1 | Application data acknowledge strobe |
| app_stop | input | 1 | Application stop strobe |
| sync_valid | input | 1 | Sync measurement present |
| sync_meas | input | MEAS_W (10) | Measured bit period in clocks |
| pid_valid | input | 1 | Identifier byte present |
| pid | input | 8 | Protected identifier |
| chk_valid | input | 1 | Checksum result present |
| chk_ok | input | 1 | Checksum matched |
| bit_sample | input | 1 | Bus bit sampled |
| tx_active | input | 1 | Node is transmitting |
| tx_bit | input | 1 | Bit being driven |
| rx_bit | input | 1 | Bit read back from the bus |
| err_clr | input | 1 | Clear all status bits |
| err_status | output | 8 | Error status value |

## Verification
Every event, including a timeout derived from the registered counters, is seen at one rising edge and appears in `err_status` right after it. The result is therefore due exactly one cycle after the stimulus. The bench changes inputs just after a falling edge and compares `err_status` at the following falling edge, so each comparison covers exactly one edge. For the timeouts, the bench counts ticks itself. It checks that the bit is still clear one tick before the limit and set on the limit tick.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEADER,
        ST_AWAIT,
        ST_DATA
    } frm_state_e;

    localparam int POS_SYNC = 4;
    localparam int POS_PAR  = 3;
    localparam int POS_TOUT = 2;
    localparam int POS_CHK  = 1;
    localparam int POS_TXB  = 0;
endpackage

// File: rtl/lin_err_id_chk.sv
module lin_err_id_chk #(
    parameter int NOM_BIT = 160,
    parameter int TOL_PCT = 14,
    parameter int MEAS_W  = 10
) (
    input  logic              slave_mode,
    input  logic              sync_valid,
    input  logic [MEAS_W-1:0] sync_meas,
    input  logic              pid_valid,
    input  logic [7:0]        pid,
    output logic              sync_ev,
    output logic              par_ev
);
    localparam int TOL_CLKS = (NOM_BIT * TOL_PCT) / 100;
    localparam logic [MEAS_W-1:0] LO_LIM = MEAS_W'(NOM_BIT - TOL_CLKS);
    localparam logic [MEAS_W-1:0] HI_LIM = MEAS_W'(NOM_BIT + TOL_CLKS);

    logic p0_exp, p1_exp;

    always_comb begin
        p0_exp  = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
        p1_exp  = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
        sync_ev = slave_mode && sync_valid &&
                  ((sync_meas < LO_LIM) || (sync_meas > HI_LIM));
        par_ev  = slave_mode && pid_valid &&
                  ((pid[6] != p0_exp) || (pid[7] != p1_exp));
    end
endmodule

// File: rtl/lin_err_frame_fsm.sv
module lin_err_frame_fsm
    import lin_err_pkg::*;
#(
    parameter int MAX_BYTES  = 8,
    parameter int RESP_TICKS = 14,
    localparam int LEN_W   = $clog2(MAX_BYTES + 1),
    localparam int LIM_MAX = ((34 + 10 * (MAX_BYTES + 1)) * 14) / 10,
    localparam int CNT_W   = $clog2(LIM_MAX + 1),
    localparam int RSP_W   = $clog2(RESP_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_start,
    input  logic             header_done,
    input  logic             byte_rx,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] data_len,
    input  logic             app_ack,
    input  logic             app_stop,
    output logic             tout_ev
);
    frm_state_e st, st_nxt;
    logic [CNT_W-1:0] frame_cnt, frame_lim;
    logic [RSP_W-1:0] resp_cnt;
    logic             ack_seen;
    logic             active;

    function automatic logic [CNT_W-1:0] len_limit(input logic [LEN_W-1:0] n);
        int t;
        t = ((34 + 10 * (int'(n) + 1)) * 14) / 10;
        return CNT_W'(t);
    endfunction

    assign active = (st != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (frame_start) begin
            st_nxt = ST_HEADER;
        end else if (tout_ev || (active && frame_done)) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_nxt = ST_IDLE;
                ST_HEADER: if (header_done) st_nxt = ST_AWAIT;
                ST_AWAIT:  if (byte_rx)     st_nxt = ST_DATA;
                ST_DATA:   st_nxt = ST_DATA;
                default:   st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            frame_lim <= '0;
            resp_cnt  <= '0;
            ack_seen  <= 1'b0;
        end else if (frame_start) begin
            frame_cnt <= '0;
            frame_lim <= len_limit(data_len);
            resp_cnt  <= '0;
            ack_seen  <= 1'b0;
        end else if (active) begin
            if (bit_tick) frame_cnt <= frame_cnt + CNT_W'(1);
            if (header_done) resp_cnt <= '0;
            else if (st == ST_AWAIT && bit_tick) resp_cnt <= resp_cnt + RSP_W'(1);
            if (app_ack || app_stop) ack_seen <= 1'b1;
        end
    end

    always_comb begin
        logic len_ev, rsp_ev, hs_ev;
        len_ev  = bit_tick && ((frame_cnt + CNT_W'(1)) == frame_lim);
        rsp_ev  = (st == ST_AWAIT) && bit_tick &&
                  ((resp_cnt + RSP_W'(1)) == RSP_W'(RESP_TICKS));
        hs_ev   = (st == ST_AWAIT) && byte_rx && !(ack_seen || app_ack || app_stop);
        tout_ev = active && !frame_start && (len_ev || rsp_ev || hs_ev);
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !frame_start) |=> (st == ST_IDLE));

    // R7
    resp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_cnt <= RSP_W'(RESP_TICKS));
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
    import lin_err_pkg::*;
#(
    parameter int NOM_BIT    = 160,
    parameter int TOL_PCT    = 14,
    parameter int MEAS_W     = 10,
    parameter int MAX_BYTES  = 8,
    parameter int RESP_TICKS = 14,
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              bit_tick,
    input  logic              frame_start,
    input  logic              header_done,
    input  logic              byte_rx,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  data_len,
    input  logic              app_ack,
    input  logic              app_stop,
    input  logic              sync_valid,
    input  logic [MEAS_W-1:0] sync_meas,
    input  logic              pid_valid,
    input  logic [7:0]        pid,
    input  logic              chk_valid,
    input  logic              chk_ok,
    input  logic              bit_sample,
    input  logic              tx_active,
    input  logic              tx_bit,
    input  logic              rx_bit,
    input  logic              err_clr,
    output logic [7:0]        err_status
);
    logic sync_ev, par_ev, tout_ev;
    logic [4:0] ev_vec, sticky;

    lin_err_id_chk #(.NOM_BIT(NOM_BIT), .TOL_PCT(TOL_PCT), .MEAS_W(MEAS_W)) u_id (
        .slave_mode(slave_mode), .sync_valid(sync_valid), .sync_meas(sync_meas),
        .pid_valid(pid_valid), .pid(pid), .sync_ev(sync_ev), .par_ev(par_ev)
    );

    lin_err_frame_fsm #(.MAX_BYTES(MAX_BYTES), .RESP_TICKS(RESP_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .header_done(header_done), .byte_rx(byte_rx), .frame_done(frame_done),
        .data_len(data_len), .app_ack(app_ack), .app_stop(app_stop), .tout_ev(tout_ev)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[POS_SYNC] = sync_ev;
        ev_vec[POS_PAR]  = par_ev;
        ev_vec[POS_TOUT] = tout_ev;
        ev_vec[POS_CHK]  = chk_valid && !chk_ok;
        ev_vec[POS_TXB]  = bit_sample && tx_active && (tx_bit != rx_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sticky <= '0;
        else if (err_clr) sticky <= ev_vec;
        else              sticky <= sticky | ev_vec;
    end

    assign err_status = {3'b000, sticky};

    // R2
    sync_master_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status[4]) |-> $past(slave_mode));

    // R3
    par_master_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status[3]) |-> $past(slave_mode));

    // R4
    chk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ok) |=> err_status[1]);

    // R5
    txbit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_sample && tx_active && (tx_bit != rx_bit)) |=> err_status[0]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(err_clr) |-> ((err_status & $past(err_status)) == $past(err_status)));
endmodule

// File: tb/tb_lin_err_monitor.sv
module tb_lin_err_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic slave_mode, bit_tick, frame_start, header_done, byte_rx, frame_done;
    logic [3:0] data_len;
    logic app_ack, app_stop, sync_valid;
    logic [9:0] sync_meas;
    logic pid_valid;
    logic [7:0] pid;
    logic chk_valid, chk_ok, bit_sample, tx_active, tx_bit, rx_bit, err_clr;
    logic [7:0] err_status;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_err_monitor dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .bit_tick(bit_tick),
        .frame_start(frame_start), .header_done(header_done), .byte_rx(byte_rx),
        .frame_done(frame_done), .data_len(data_len), .app_ack(app_ack),
        .app_stop(app_stop), .sync_valid(sync_valid), .sync_meas(sync_meas),
        .pid_valid(pid_valid), .pid(pid), .chk_valid(chk_valid), .chk_ok(chk_ok),
        .bit_sample(bit_sample), .tx_active(tx_active), .tx_bit(tx_bit),
        .rx_bit(rx_bit), .err_clr(err_clr), .err_status(err_status)
    );

    function automatic logic sync_bad(input logic [9:0] m);
        int lo, hi;
        lo = 160 - (160 * 14) / 100;
        hi = 160 + (160 * 14) / 100;
        return (int'(m) < lo) || (int'(m) > hi);
    endfunction

    function automatic logic par_bad(input logic [7:0] p);
        logic a, b;
        a = p[0] ^ p[1] ^ p[2] ^ p[4];
        b = ~(p[1] ^ p[3] ^ p[4] ^ p[5]);
        return (p[6] != a) || (p[7] != b);
    endfunction

    function automatic int len_lim(input int n);
        return ((34 + 10 * (n + 1)) * 14) / 10;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: err_status=%02h expected %02h", req, act, exp);
        end
    endtask

    task automatic quiet();
        bit_tick = 0; frame_start = 0; header_done = 0; byte_rx = 0; frame_done = 0;
        app_ack = 0; app_stop = 0; sync_valid = 0; pid_valid = 0; chk_valid = 0;
        chk_ok = 1; bit_sample = 0; tx_active = 0; tx_bit = 0; rx_bit = 0; err_clr = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        quiet();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1;
            cyc();
        end
    endtask

    task automatic clr_all();
        err_clr = 1;
        cyc();
    endtask

    task automatic len_case(input int n);
        int lim;
        lim = len_lim(n);
        clr_all();
        data_len = 4'(n); frame_start = 1; cyc();
        ticks(10);
        header_done = 1; app_ack = 1; cyc();
        byte_rx = 1; cyc();
        ticks(lim - 11);
        check("R6 one tick before limit", err_status, 8'h00);
        ticks(1);
        check("R6 limit tick", err_status, 8'h04);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5521));
        quiet();
        slave_mode = 1; data_len = 4'd1; sync_meas = '0; pid = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 reset value", err_status, 8'h00);
        rst_n = 1;
        cyc();
        check("R1 after release", err_status, 8'h00);

        // Random events with no frame active: R2, R3, R4, R5, R9
        exp_st = 8'h00;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ev;
            slave_mode = 1'($urandom);
            sync_valid = ($urandom % 4) == 0;
            sync_meas  = 10'(120 + $urandom % 80);
            pid_valid  = ($urandom % 4) == 0;
            pid        = 8'($urandom);
            chk_valid  = ($urandom % 6) == 0;
            chk_ok     = 1'($urandom);
            bit_sample = ($urandom % 3) == 0;
            tx_active  = 1'($urandom);
            tx_bit     = 1'($urandom);
            rx_bit     = 1'($urandom);
            err_clr    = ($urandom % 8) == 0;
            ev = 8'h00;
            ev[4] = slave_mode && sync_valid && sync_bad(sync_meas);
            ev[3] = slave_mode && pid_valid && par_bad(pid);
            ev[1] = chk_valid && !chk_ok;
            ev[0] = bit_sample && tx_active && (tx_bit != rx_bit);
            exp_st = (err_clr ? 8'h00 : exp_st) | ev;
            cyc();
            check("R2/R3/R4/R5/R9 random", err_status, exp_st);
        end

        // R2 window edges, slave mode
        slave_mode = 1;
        clr_all();
        sync_valid = 1; sync_meas = 10'd138; cyc();
        sync_valid = 1; sync_meas = 10'd182; cyc();
        check("R2 edges inside", err_status, 8'h00);
        sync_valid = 1; sync_meas = 10'd137; cyc();
        check("R2 below window", err_status, 8'h10);
        clr_all();
        sync_valid = 1; sync_meas = 10'd183; cyc();
        check("R2 above window", err_status, 8'h10);
        clr_all();
        slave_mode = 0; sync_valid = 1; sync_meas = 10'd20; cyc();
        pid_valid = 1; pid = 8'h00; cyc();
        check("R2/R3 ignored in master", err_status, 8'h00);
        slave_mode = 1;
        pid_valid = 1; pid = 8'h80; cyc();
        check("R3 good identifier 0x80", err_status, 8'h00);
        pid_valid = 1; pid = 8'h00; cyc();
        check("R3 bad identifier 0x00", err_status, 8'h08);

        // R9 clear against same-cycle event
        chk_valid = 1; chk_ok = 0; cyc();
        check("R4 checksum fault", err_status, 8'h0A);
        err_clr = 1; bit_sample = 1; tx_active = 1; tx_bit = 1; rx_bit = 0; cyc();
        check("R9 event wins over clear", err_status, 8'h01);
        cyc();
        check("R9 sticky hold", err_status, 8'h01);
        clr_all();
        check("R9 clear", err_status, 8'h00);

        // R6 frame-length limit
        len_case(1);
        len_case(8);

        // R7 response window
        clr_all();
        data_len = 4'd1; frame_start = 1; cyc();
        header_done = 1; app_ack = 1; cyc();
        ticks(13);
        check("R7 before window end", err_status, 8'h00);
        ticks(1);
        check("R7 window expired", err_status, 8'h04);

        // R8 handshake deadline
        clr_all();
        frame_start = 1; cyc();
        header_done = 1; cyc();
        byte_rx = 1; cyc();
        check("R8 no acknowledge", err_status, 8'h04);
        clr_all();
        frame_start = 1; cyc();
        header_done = 1; cyc();
        app_stop = 1; byte_rx = 1; cyc();
        check("R8 stop given in time", err_status, 8'h00);
        frame_done = 1; cyc();

        // R10 idle and restart
        clr_all();
        frame_start = 1; cyc();
        header_done = 1; app_ack = 1; cyc();
        byte_rx = 1; cyc();
        frame_done = 1; cyc();
        ticks(100);
        check("R10 no timeout when idle", err_status, 8'h00);
        frame_start = 1; data_len = 4'd1; cyc();
        header_done = 1; app_ack = 1; cyc();
        byte_rx = 1; cyc();
        ticks(70);
        frame_start = 1; cyc();
        header_done = 1; app_ack = 1; cyc();
        byte_rx = 1; cyc();
        ticks(74);
        check("R10 restart reset count", err_status, 8'h00);
        ticks(1);
        check("R10 limit after restart", err_status, 8'h04);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule